// File: doc/BRIEF.md
# Memory Access Reorder Detector

This block watches the processor's data port to memory. Accesses reach it in the order they complete. Each one carries the program-order tag it was given at issue. The block keeps a small log of recent loads and stores. Each new access is compared by address against every valid log entry in a single cycle. The wrap-aware tag comparison then shows whether the new access is older in program order than something that has already gone out.

Two outcomes need repair. When a late store is older than an already-sent store to the same address, the value of the program-order-later store must be the one memory keeps. A parameter selects how that is done:

- **Resend mode:** the late store is passed on, and in the next cycle the youngest such store is sent again. That repeat owns the memory port for one transfer.
- **Block mode:** the late store is dropped.

When a load and a store to one address are found reversed, nothing at the port can repair it. The block withholds the access, raises a rollback request carrying its tag, and clears every log entry younger than that tag. Entries leave the log when the processor commits up to a tag. When the log is full, the port is stalled.

Top module: `mem_order_guard`

## Requirements
- R1: After reset the log is empty, `acc_ready` is 1, and `mem_valid` and `rb_valid` are 0.
- R2: An accepted access that has no reversal with a logged entry appears on the memory port in the same cycle with the same direction, address, data and tag, and `rb_valid` stays 0.
- R3: The log holds DEPTH (default 8) entries. With all of them valid, `acc_ready` is 0. An access offered while `acc_ready` is 0 is neither forwarded nor logged, and it raises no rollback.
- R4: While `commit_valid` is 1, every entry whose tag is at or before `commit_tag` is retired at the clock edge. This frees log space and removes the entry from later matching.
- R5: Tag `a` is older than tag `b` exactly when `(a - b) mod 16` is 8 or more. For example, tag 15 is older than tag 0, and tag 13 is older than tag 14.
- R6: Resend mode. When an accepted store is older than a logged store to the same address, the store is forwarded in that cycle. In the next cycle the port carries a write of the youngest such logged store (its address, data and tag), with `acc_ready` at 0 for that one cycle only.
- R7: Block mode. The late older store described in R6 is not forwarded, and it raises no rollback.
- R8: When an accepted access is older than a logged access of the opposite direction (load versus store) at the same address, `rb_valid` is 1 in that cycle and `rb_tag` equals the access's tag. That access is not forwarded.
- R9: A rollback clears, at that clock edge, every log entry whose tag is younger than `rb_tag`. A later access to the same address then sees no reversal against those entries.
- R10: Two loads to one address that complete out of order are not a reversal: the late load is forwarded with no rollback.
- R11: Matching needs an identical 32-bit address. An older access to a different address is forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Processor presents an access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Store data |
| acc_tag | input | 4 | Issue-order tag |
| acc_ready | output | 1 | Access can be taken this cycle |
| commit_valid | input | 1 | Retire entries up to `commit_tag` |
| commit_tag | input | 4 | Last committed tag |
| mem_valid | output | 1 | Transfer to memory this cycle |
| mem_write | output | 1 | Transfer is a store |
| mem_addr | output | 32 | Transfer address |
| mem_data | output | 32 | Transfer data |
| mem_tag | output | 4 | Tag of the transfer |
| rb_valid | output | 1 | Rollback request |
| rb_tag | output | 4 | Oldest offending tag |

## Verification
Some properties are checked on every cycle:
- a full log always deasserts `acc_ready`;
- a rollback is never forwarded and always carries the tag of the access just taken;
- a rollback never makes the log grow;
- a memory transfer made without an accepted access never lasts two cycles in a row.

Other behaviour can only be shown by the bench's scenarios: which store is chosen for the resend, the wrap of tags across 15 to 0, which entries a rollback or a commit clears, and the difference between resend and block mode.

// File: rtl/mog_pkg.sv
package mog_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  valid;
        logic  wr;
        addr_t addr;
        tag_t  tag;
        data_t data;
    } entry_t;

    typedef enum logic {
        FIX_BLOCK  = 1'b0,
        FIX_RESEND = 1'b1
    } fix_e;

    // a older than b in wrapped tag space
    function automatic logic is_older(tag_t a, tag_t b);
        tag_t d;
        d = a - b;
        return d[TAG_W-1];
    endfunction
endpackage

// File: rtl/mog_log.sv
module mog_log
    import mog_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  entry_t                 wr_entry,
    input  logic                   commit_en,
    input  tag_t                   commit_tag,
    input  logic                   flush_en,
    input  tag_t                   flush_tag,
    output entry_t [DEPTH-1:0]     entries,
    output logic                   full
);
    entry_t [DEPTH-1:0] mem_q;
    logic   [IDX_W-1:0] free_idx;
    logic               found;

    always_comb begin
        free_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && !mem_q[i].valid) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        full = !found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (commit_en && mem_q[i].valid && !is_older(commit_tag, mem_q[i].tag))
                    mem_q[i].valid <= 1'b0;
                if (flush_en && mem_q[i].valid && is_older(flush_tag, mem_q[i].tag))
                    mem_q[i].valid <= 1'b0;
            end
            if (wr_en && !full) mem_q[free_idx] <= wr_entry;
        end
    end

    assign entries = mem_q;
endmodule

// File: rtl/mog_judge.sv
module mog_judge
    import mog_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  entry_t [DEPTH-1:0] entries,
    input  logic               acc_wr,
    input  addr_t              acc_addr,
    input  tag_t               acc_tag,
    output logic               rw_hit,
    output logic               ww_hit,
    output entry_t             rs_entry
);
    always_comb begin
        logic later;
        rw_hit   = 1'b0;
        ww_hit   = 1'b0;
        rs_entry = '0;
        for (int i = 0; i < DEPTH; i++) begin
            later = entries[i].valid && (entries[i].addr == acc_addr)
                    && is_older(acc_tag, entries[i].tag);
            if (later && (entries[i].wr != acc_wr)) rw_hit = 1'b1;
            if (later && entries[i].wr && acc_wr) begin
                if (!ww_hit || is_older(rs_entry.tag, entries[i].tag))
                    rs_entry = entries[i];
                ww_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mem_order_guard.sv
module mem_order_guard
    import mog_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter fix_e FIX   = FIX_RESEND
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] acc_addr,
    input  logic [31:0] acc_data,
    input  logic [3:0]  acc_tag,
    output logic        acc_ready,
    input  logic        commit_valid,
    input  logic [3:0]  commit_tag,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    output logic [3:0]  mem_tag,
    output logic        rb_valid,
    output logic [3:0]  rb_tag
);
    entry_t [DEPTH-1:0] entries;
    entry_t             rs_entry;
    entry_t             rs_q;
    entry_t             new_entry;
    logic               full, rw_hit, ww_hit;
    logic               accept, rollback, ww_fix, drop_now;
    logic [DEPTH-1:0]   valid_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign valid_vec[i] = entries[i].valid;
    end

    assign acc_ready = !full && !rs_q.valid;
    assign accept    = acc_valid && acc_ready;
    assign rollback  = accept && rw_hit;
    assign ww_fix    = accept && !rw_hit && ww_hit;
    assign drop_now  = ww_fix && (FIX == FIX_BLOCK);

    always_comb begin
        new_entry       = '0;
        new_entry.valid = 1'b1;
        new_entry.wr    = acc_write;
        new_entry.addr  = acc_addr;
        new_entry.tag   = acc_tag;
        new_entry.data  = acc_write ? acc_data : '0;
    end

    mog_log #(.DEPTH(DEPTH)) u_log (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept && !rw_hit),
        .wr_entry   (new_entry),
        .commit_en  (commit_valid),
        .commit_tag (commit_tag),
        .flush_en   (rollback),
        .flush_tag  (acc_tag),
        .entries    (entries),
        .full       (full)
    );

    mog_judge #(.DEPTH(DEPTH)) u_judge (
        .entries  (entries),
        .acc_wr   (acc_write),
        .acc_addr (acc_addr),
        .acc_tag  (acc_tag),
        .rw_hit   (rw_hit),
        .ww_hit   (ww_hit),
        .rs_entry (rs_entry)
    );

    if (FIX == FIX_RESEND) begin : g_resend
        always_ff @(posedge clk) begin
            if (rst)         rs_q <= '0;
            else if (ww_fix) rs_q <= rs_entry;
            else             rs_q <= '0;
        end
    end else begin : g_block
        assign rs_q = '0;
    end

    always_comb begin
        if (rs_q.valid) begin
            mem_valid = 1'b1;
            mem_write = rs_q.wr;
            mem_addr  = rs_q.addr;
            mem_data  = rs_q.data;
            mem_tag   = rs_q.tag;
        end else begin
            mem_valid = accept && !rw_hit && !drop_now;
            mem_write = acc_write;
            mem_addr  = acc_addr;
            mem_data  = acc_data;
            mem_tag   = acc_tag;
        end
    end

    assign rb_valid = rollback;
    assign rb_tag   = acc_tag;
endmodule

// File: rtl/mog_checker.sv
module mog_checker #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_ready,
    input logic [3:0]       acc_tag,
    input logic             mem_valid,
    input logic             rb_valid,
    input logic [3:0]       rb_tag,
    input logic [DEPTH-1:0] valid_vec
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && !mem_valid)); // R1
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        ($countones(valid_vec) == DEPTH) |-> !acc_ready); // R3
    AST_RB_NOT_SENT: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> !mem_valid); // R8
    AST_RB_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> (acc_valid && acc_ready && rb_tag == acc_tag)); // R8
    AST_RESEND_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !(acc_valid && acc_ready)) |=> !(mem_valid && !(acc_valid && acc_ready))); // R6
    AST_RB_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> ($countones(valid_vec) <= $past($countones(valid_vec)))); // R9
endmodule

bind mem_order_guard mog_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_tag   (acc_tag),
    .mem_valid (mem_valid),
    .rb_valid  (rb_valid),
    .rb_tag    (rb_tag),
    .valid_vec (valid_vec)
);

// File: tb/tb_mem_order_guard.sv
module tb_mem_order_guard;
    import mog_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 0, acc_write = 0, commit_valid = 0;
    logic [31:0] acc_addr = '0, acc_data = '0;
    logic [3:0]  acc_tag = '0, commit_tag = '0;

    logic acc_ready, mem_valid, mem_write, rb_valid;
    logic [31:0] mem_addr, mem_data;
    logic [3:0]  mem_tag, rb_tag;
    logic b_ready, b_mv, b_mw, b_rb;
    logic [31:0] b_maddr, b_mdata;
    logic [3:0]  b_mtag, b_rbtag;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_guard #(.DEPTH(8), .FIX(FIX_RESEND)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_data(acc_data), .acc_tag(acc_tag),
        .acc_ready(acc_ready), .commit_valid(commit_valid), .commit_tag(commit_tag),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_tag(mem_tag), .rb_valid(rb_valid), .rb_tag(rb_tag));

    mem_order_guard #(.DEPTH(8), .FIX(FIX_BLOCK)) dut_blk (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_data(acc_data), .acc_tag(acc_tag),
        .acc_ready(b_ready), .commit_valid(commit_valid), .commit_tag(commit_tag),
        .mem_valid(b_mv), .mem_write(b_mw), .mem_addr(b_maddr),
        .mem_data(b_mdata), .mem_tag(b_mtag), .rb_valid(b_rb), .rb_tag(b_rbtag));

    typedef struct packed {
        logic        av;
        logic        aw;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  tag;
        logic        e_rdy;
        logic        e_mv;
        logic        e_mw;
        logic [31:0] e_maddr;
        logic [31:0] e_mdata;
        logic [3:0]  e_mtag;
        logic        e_rb;
        logic [3:0]  e_rbtag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,32'h100,32'h11,4'd2,  1'b1,1'b1,1'b1,32'h100,32'h11,4'd2,  1'b0,4'd0},  // R2
        '{1'b1,1'b0,32'h200,32'h0, 4'd3,  1'b1,1'b1,1'b0,32'h200,32'h0, 4'd3,  1'b0,4'd0},  // R2
        '{1'b1,1'b1,32'h100,32'h22,4'd1,  1'b1,1'b1,1'b1,32'h100,32'h22,4'd1,  1'b0,4'd0},  // R6 late store sent
        '{1'b0,1'b0,32'h0,  32'h0, 4'd0,  1'b0,1'b1,1'b1,32'h100,32'h11,4'd2,  1'b0,4'd0},  // R6 resend
        '{1'b1,1'b0,32'h200,32'h0, 4'd0,  1'b1,1'b1,1'b0,32'h200,32'h0, 4'd0,  1'b0,4'd0},  // R10
        '{1'b1,1'b0,32'h100,32'h0, 4'd0,  1'b1,1'b0,1'b0,32'h0,  32'h0, 4'd0,  1'b1,4'd0},  // R8 late load
        '{1'b1,1'b1,32'h200,32'h66,4'd15, 1'b1,1'b0,1'b0,32'h0,  32'h0, 4'd0,  1'b1,4'd15}, // R8 R5 late store
        '{1'b1,1'b1,32'h100,32'h44,4'd0,  1'b1,1'b1,1'b1,32'h100,32'h44,4'd0,  1'b0,4'd0},  // R9
        '{1'b1,1'b1,32'h104,32'h77,4'd15, 1'b1,1'b1,1'b1,32'h104,32'h77,4'd15, 1'b0,4'd0},  // R11
        '{1'b1,1'b1,32'h100,32'h33,4'd14, 1'b1,1'b1,1'b1,32'h100,32'h33,4'd14, 1'b0,4'd0},  // R5 wrap
        '{1'b0,1'b0,32'h0,  32'h0, 4'd0,  1'b0,1'b1,1'b1,32'h100,32'h44,4'd0,  1'b0,4'd0},  // R5 R6
        '{1'b1,1'b1,32'h100,32'h55,4'd13, 1'b1,1'b1,1'b1,32'h100,32'h55,4'd13, 1'b0,4'd0},  // R6
        '{1'b0,1'b0,32'h0,  32'h0, 4'd0,  1'b0,1'b1,1'b1,32'h100,32'h44,4'd0,  1'b0,4'd0}   // R6 youngest
    };

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic av, logic aw, logic [31:0] ad, logic [31:0] dt, logic [3:0] tg);
        @(negedge clk);
        acc_valid = av; acc_write = aw; acc_addr = ad; acc_data = dt; acc_tag = tg;
        commit_valid = 1'b0;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; commit_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset state", {125'd0, acc_ready, mem_valid, rb_valid}, {125'd0, 3'b100});

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].av, VECS[i].aw, VECS[i].addr, VECS[i].data, VECS[i].tag);
            check($sformatf("R2/R5/R6/R8/R9/R10/R11 vector %0d ready,valid,rb", i),
                  {125'd0, acc_ready, mem_valid, rb_valid},
                  {125'd0, VECS[i].e_rdy, VECS[i].e_mv, VECS[i].e_rb});
            if (VECS[i].e_mv)
                check($sformatf("R2/R6 vector %0d transfer", i),
                      {59'd0, mem_write, mem_addr, mem_data, mem_tag},
                      {59'd0, VECS[i].e_mw, VECS[i].e_maddr, VECS[i].e_mdata, VECS[i].e_mtag});
            if (VECS[i].e_rb)
                check($sformatf("R8 vector %0d rollback tag", i), {124'd0, rb_tag}, {124'd0, VECS[i].e_rbtag});
        end

        // R4: commit up to tag 0 retires tags 13,14,15,0 (all at or before 0)
        @(negedge clk);
        acc_valid = 1'b0; commit_valid = 1'b1; commit_tag = 4'd0;
        drive(1'b1, 1'b0, 32'h100, 32'h0, 4'd1);
        check("R4 load after commit forwarded, no rollback",
              {126'd0, mem_valid, rb_valid}, {126'd0, 2'b10});

        // R1 again after a busy log
        do_reset();
        check("R1 reset after activity", {125'd0, acc_ready, mem_valid, rb_valid}, {125'd0, 3'b100});

        // R3: fill the log with 8 loads
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b0, 32'h1000 + 32'(4*k), 32'h0, 4'(k));
            check($sformatf("R3 fill load %0d forwarded", k), {127'd0, mem_valid}, {127'd0, 1'b1});
        end
        drive(1'b1, 1'b1, 32'h1004, 32'h99, 4'd0);
        check("R3 full log stalls and ignores access",
              {125'd0, acc_ready, mem_valid, rb_valid}, {125'd0, 3'b000});
        @(negedge clk);
        acc_valid = 1'b0; commit_valid = 1'b1; commit_tag = 4'd0;
        #2;
        check("R3 still stalled during commit cycle", {127'd0, acc_ready}, {127'd0, 1'b0});
        @(negedge clk);
        commit_valid = 1'b0;
        #2;
        check("R4 commit frees a slot", {127'd0, acc_ready}, {127'd0, 1'b1});

        // R7: block mode drops the late older store
        do_reset();
        drive(1'b1, 1'b1, 32'h100, 32'h1, 4'd5);
        check("R7 block mode first store forwarded", {127'd0, b_mv}, {127'd0, 1'b1});
        drive(1'b1, 1'b1, 32'h100, 32'h2, 4'd4);
        check("R7 block mode late store dropped",
              {125'd0, b_ready, b_mv, b_rb}, {125'd0, 3'b100});
        drive(1'b0, 1'b0, 32'h0, 32'h0, 4'd0);
        check("R7 block mode no follow-up transfer",
              {126'd0, b_ready, b_mv}, {126'd0, 2'b10});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule